// File: doc/BRIEF.md
# Time-Sliced Video RAM Access Arbiter

This block shares one video RAM port between a display fetch engine and a host CPU. The CPU runs on its own clock. Each scan line is cut into a fixed number of access windows on the video clock, and each window is split into two parts. The opening positions of a window always belong to the display fetch engine. The closing positions can carry one CPU access, but only when the CPU has a request waiting. The display fetch timing never moves, whatever the CPU is doing.

A CPU request first passes through a flop chain into the video clock domain. While the request waits for a usable position, the block holds the CPU with a wait output. The CPU clock can only be halted or released on half-cycle boundaries. For that reason a CPU access is issued only on a video cycle where the synchronised CPU clock phase input has just changed level. This keeps the final part of the stretched CPU cycle inside the CPU part of the window. A request that arrives too late in a window to finish is carried over to the next window. A start-of-line pulse marks position zero of window zero, so the rest of the video chain can follow the line.

Top module: `vram_slot_arbiter`

## Requirements
- R1: A position counter runs 0..15 within a window and a window counter runs 0..56 within a line. Both wrap to zero together. `line_start` is high exactly when both are zero, which happens once every 912 cycles.
- R2: A decision is made at positions 0..9 and appears on the outputs one cycle later. At each such decision, `ram_en` and `disp_ack` equal `disp_req`, `ram_addr` equals `disp_addr` whenever `disp_req` is high, and `ram_we` is 0. This holds regardless of CPU activity.
- R3: A CPU strobe (`ram_en` high with `disp_ack` low) is decided only at positions 10..14, never at position 15. No strobe is produced at positions 10..15 unless a CPU request is active.
- R4: `cpu_req` passes through two flops. If `cpu_req` is high at an edge, `cpu_wait` is high after the second following edge.
- R5: The CPU strobe is decided at the first eligible position that comes two or more cycles after the edge that first samples `cpu_req`. If no eligible position is left in the current window, the request waits for position 10 of a later window, and `cpu_wait` stays high meanwhile.
- R6: A CPU strobe is decided only at an edge where `cpu_phase` differs from its value at the previous edge. While `cpu_phase` holds still, the request keeps waiting.
- R7: A CPU strobe drives `ram_addr`=`cpu_addr` and `ram_we`=`cpu_we`, and on a write also `ram_wdata`=`cpu_wdata`. At the edge after the strobe becomes visible, `cpu_rdata` captures `ram_rdata` for a read, and `cpu_wait` falls.
- R8: Each assertion of `cpu_req` produces exactly one CPU strobe, however long the request is then held.
- R9: Synchronous reset clears `ram_en`, `ram_we`, `disp_ack`, `cpu_wait` and both counters, so `line_start` is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU video RAM request, CPU clock domain |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 16 | CPU access address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_phase | input | 1 | CPU clock level, already synchronised to the video clock |
| cpu_wait | output | 1 | Holds the CPU until its access completes |
| cpu_rdata | output | 8 | Data returned for a CPU read |
| disp_req | input | 1 | Display fetch wants the current position |
| disp_addr | input | 16 | Display fetch address |
| disp_ack | output | 1 | Display fetch was issued on the RAM port |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid for the address currently presented |
| line_start | output | 1 | High at position 0 of window 0 |

## Verification
The bench builds the block with its default parameters: 16-cycle windows, 10 display positions, a one-position closing guard, 57 windows per line and a two-flop synchroniser. With the one-position guard, the last usable CPU position is 14. Requests placed at positions 13 and 14 therefore reach the carry-over to the next window, while earlier positions are served in the same window. Because the real 912-cycle line is kept, the start-of-line spacing is observed directly within a short run. Holding the phase input still exposes the half-step gate.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  typedef enum logic [1:0] {
    SLOT_DISPLAY,
    SLOT_CPU_OPEN,
    SLOT_CPU_CLOSED
  } slot_kind_e;

  // Class of a window position: display part, usable CPU part, or the
  // closing guard where a CPU access could not finish in time.
  function automatic slot_kind_e slot_kind(input int p, input int disp_len,
                                           input int last_open);
    if (p < disp_len)       return SLOT_DISPLAY;
    else if (p <= last_open) return SLOT_CPU_OPEN;
    else                    return SLOT_CPU_CLOSED;
  endfunction

endpackage

// File: rtl/vram_slot_timer.sv
module vram_slot_timer #(
  parameter int WIN_CYCLES   = 16,
  parameter int LINE_WINDOWS = 57
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [$clog2(WIN_CYCLES)-1:0] pos,
  output logic                          line_start
);
  localparam int POS_W    = $clog2(WIN_CYCLES);
  localparam int WIN_W    = $clog2(LINE_WINDOWS);
  localparam int POS_LAST = WIN_CYCLES - 1;
  localparam int WIN_LAST = LINE_WINDOWS - 1;

  logic [WIN_W-1:0] win;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      win <= '0;
    end else if (pos == POS_W'(POS_LAST)) begin
      pos <= '0;
      win <= (win == WIN_W'(WIN_LAST)) ? '0 : win + 1'b1;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  assign line_start = (pos == '0) && (win == '0);

  p_pos_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (pos == POS_W'(POS_LAST)) |=> (pos == '0));

  p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (pos == POS_W'(POS_LAST) && win == WIN_W'(WIN_LAST)) |=> line_start);

  p_win_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (pos != POS_W'(POS_LAST)) |=> $stable(win));

endmodule

// File: rtl/vram_req_sync.sv
module vram_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/vram_slot_arbiter.sv
module vram_slot_arbiter
  import vram_arb_pkg::*;
#(
  parameter int WIN_CYCLES   = 16,
  parameter int LINE_WINDOWS = 57,
  parameter int DISP_CYCLES  = 10,
  parameter int TAIL_GUARD   = 1,
  parameter int SYNC_STAGES  = 2,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_phase,
  output logic              cpu_wait,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              disp_req,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic              disp_ack,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              line_start
);
  localparam int POS_W     = $clog2(WIN_CYCLES);
  localparam int LAST_OPEN = WIN_CYCLES - 1 - TAIL_GUARD;

  logic [POS_W-1:0] pos;
  logic             req_s;
  logic             phase_q;
  logic             phase_edge;
  logic             served;
  logic             acc_pend;
  logic             grant;
  slot_kind_e       kind;
  logic [1:0]       age;

  vram_slot_timer #(
    .WIN_CYCLES  (WIN_CYCLES),
    .LINE_WINDOWS(LINE_WINDOWS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .pos       (pos),
    .line_start(line_start)
  );

  vram_req_sync #(
    .STAGES(SYNC_STAGES)
  ) u_req_sync (
    .clk(clk),
    .rst(rst),
    .d  (cpu_req),
    .q  (req_s)
  );

  always_comb kind = slot_kind(int'(pos), DISP_CYCLES, LAST_OPEN);

  assign phase_edge = cpu_phase ^ phase_q;
  assign grant      = req_s & ~served & ~acc_pend & phase_edge
                      & (kind == SLOT_CPU_OPEN);
  assign cpu_wait   = req_s & ~served;

  // Request bookkeeping: one access per request level.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= 1'b0;
      served    <= 1'b0;
      acc_pend  <= 1'b0;
      cpu_rdata <= '0;
      age       <= '0;
    end else begin
      phase_q  <= cpu_phase;
      acc_pend <= grant;
      age      <= (age == 2'd3) ? age : age + 1'b1;
      if (acc_pend && !ram_we) cpu_rdata <= ram_rdata;
      if (!req_s)         served <= 1'b0;
      else if (acc_pend)  served <= 1'b1;
    end
  end

  // RAM port: display owns its part unconditionally, CPU only on grant.
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en    <= 1'b0;
      ram_we    <= 1'b0;
      disp_ack  <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else if (kind == SLOT_DISPLAY) begin
      ram_en   <= disp_req;
      ram_we   <= 1'b0;
      disp_ack <= disp_req;
      ram_addr <= disp_addr;
    end else if (grant) begin
      ram_en    <= 1'b1;
      ram_we    <= cpu_we;
      disp_ack  <= 1'b0;
      ram_addr  <= cpu_addr;
      ram_wdata <= cpu_wdata;
    end else begin
      ram_en   <= 1'b0;
      ram_we   <= 1'b0;
      disp_ack <= 1'b0;
    end
  end

  p_display_owner_r2: assert property (@(posedge clk) disable iff (rst || age == 2'd0)
    ($past(pos) < POS_W'(DISP_CYCLES)) |-> (ram_en == $past(disp_req) && !ram_we));

  p_cpu_part_only_r3: assert property (@(posedge clk) disable iff (rst || age == 2'd0)
    (ram_en && !disp_ack) |-> ($past(pos) >= POS_W'(DISP_CYCLES)
                              && $past(pos) <= POS_W'(LAST_OPEN)));

  p_cpu_was_held_r5: assert property (@(posedge clk) disable iff (rst || age == 2'd0)
    (ram_en && !disp_ack) |-> $past(cpu_wait));

  p_half_step_r6: assert property (@(posedge clk) disable iff (rst || age < 2'd2)
    (ram_en && !disp_ack) |-> ($past(cpu_phase) != $past(cpu_phase, 2)));

  p_release_r7: assert property (@(posedge clk) disable iff (rst || age == 2'd0)
    (ram_en && !disp_ack) |=> !cpu_wait);

endmodule

// File: tb/test_vram_slot_arbiter.sv
module test_vram_slot_arbiter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_phase = 1'b0;
  logic        cpu_wait;
  logic [7:0]  cpu_rdata;
  logic        disp_req = 1'b0;
  logic [15:0] disp_addr = '0;
  logic        disp_ack;
  logic        ram_en;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;
  logic        line_start;

  always #5 clk = ~clk;

  vram_slot_arbiter i_vram_slot_arbiter (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_phase(cpu_phase),
    .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata), .disp_req(disp_req),
    .disp_addr(disp_addr), .disp_ack(disp_ack), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .line_start(line_start)
  );

  // RAM model: read data is a fixed function of the presented address.
  assign ram_rdata = ram_addr[7:0] ^ 8'h5A;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference position tracking, driven display traffic, CPU phase.
  int   rc = 0, rw = 0, nc, nw;
  int   prev_pos = 0;
  bit   prev_dreq = 1'b0;
  logic [15:0] prev_daddr = '0;
  bit   ph_run = 1'b1;
  bit   cpu_expect = 1'b0;
  int   cpu_strobes = 0;
  int   ls_gap = 0;
  int   ls_seen = 0;

  always @(negedge clk) begin
    if (rst) begin
      rc = 0; rw = 0; ls_gap = 0;
    end else begin
      if (prev_pos < 10) begin
        chk((ram_en == prev_dreq) && !ram_we && (disp_ack == prev_dreq)
            && (!prev_dreq || ram_addr == prev_daddr), "R2", int'(ram_addr), int'(prev_daddr));
      end else begin
        chk(!disp_ack, "R2 no ack in cpu part", int'(disp_ack), 0);
        if (ram_en) begin
          cpu_strobes++;
          chk(prev_pos <= 14 && cpu_expect, "R3", prev_pos, 14);
        end
      end
      nc = (rc == 15) ? 0 : rc + 1;
      nw = (rc == 15) ? ((rw == 56) ? 0 : rw + 1) : rw;
      rc = nc; rw = nw;
      chk(line_start == (rc == 0 && rw == 0), "R1 line_start position", int'(line_start), int'(rc == 0 && rw == 0));
      ls_gap++;
      if (line_start) begin
        chk(ls_gap == 912, "R1 line length", ls_gap, 912);
        ls_seen++;
        ls_gap = 0;
      end
    end
    prev_pos   = rc;
    disp_req   = ((rc + rw) % 3) != 0;
    disp_addr  = {4'hF, 6'(rw), 4'(rc), 2'b00};
    prev_dreq  = disp_req;
    prev_daddr = disp_addr;
    if (ph_run) cpu_phase = ~cpu_phase;
  end

  task automatic go_pos(input int p);
    do begin
      @(negedge clk); #1;
    end while (rc != p);
  endtask

  typedef struct packed {
    logic [3:0]  p0;
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [4:0]  d;
  } vec_t;

  // start position, direction, address, write data, expected decision delay
  localparam vec_t VECS [8] = '{
    '{4'd0,  1'b1, 16'h0123, 8'hA1, 5'd10},
    '{4'd5,  1'b0, 16'h0456, 8'h00, 5'd5},
    '{4'd8,  1'b1, 16'h0789, 8'h3C, 5'd2},
    '{4'd12, 1'b0, 16'h1ABC, 8'h00, 5'd2},
    '{4'd13, 1'b1, 16'h2DEF, 8'h77, 5'd13},
    '{4'd9,  1'b0, 16'h3001, 8'h00, 5'd2},
    '{4'd14, 1'b1, 16'h4002, 8'hE5, 5'd12},
    '{4'd3,  1'b0, 16'h5003, 8'h00, 5'd7}
  };

  task automatic cpu_access(input vec_t v);
    int cs0;
    go_pos(int'(v.p0));
    cpu_req = 1'b1; cpu_we = v.we; cpu_addr = v.addr; cpu_wdata = v.wd;
    cpu_expect = 1'b1;
    cs0 = cpu_strobes;
    for (int k = 1; k <= int'(v.d) + 2; k++) begin
      @(negedge clk); #1;
      if (k == 2) chk(cpu_wait, "R4 wait after two flops", int'(cpu_wait), 1);
      if (k == int'(v.d)) begin
        chk(cpu_strobes == cs0, "R5 no early strobe", cpu_strobes - cs0, 0);
        chk(cpu_wait, "R5 held", int'(cpu_wait), 1);
      end
      if (k == int'(v.d) + 1) begin
        chk(ram_en && !disp_ack && ram_addr == v.addr, "R5 strobe position", int'(ram_addr), int'(v.addr));
        chk(ram_we == v.we && (!v.we || ram_wdata == v.wd), "R7 write fields", int'(ram_wdata), int'(v.wd));
      end
      if (k == int'(v.d) + 2) begin
        chk(!cpu_wait, "R7 wait released", int'(cpu_wait), 0);
        if (!v.we) chk(cpu_rdata == (v.addr[7:0] ^ 8'h5A), "R7 read data", int'(cpu_rdata), int'(v.addr[7:0] ^ 8'h5A));
      end
    end
    repeat (20) @(negedge clk);
    #1;
    chk(cpu_strobes == cs0 + 1, "R8 single access", cpu_strobes - cs0, 1);
    chk(!cpu_wait, "R8 wait stays low", int'(cpu_wait), 0);
    cpu_req = 1'b0;
    repeat (4) @(negedge clk);
    cpu_expect = 1'b0;
  endtask

  initial begin
    int cs0;
    repeat (4) @(negedge clk);
    #1;
    chk(!ram_en && !ram_we && !disp_ack && !cpu_wait, "R9 outputs in reset", int'(ram_en), 0);
    chk(line_start, "R9 counters cleared", int'(line_start), 1);
    @(negedge clk); #1;
    rst = 1'b0;

    foreach (VECS[i]) cpu_access(VECS[i]);

    // R6: frozen phase blocks the grant until the phase moves again.
    ph_run = 1'b0;
    go_pos(8);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h6006; cpu_wdata = 8'h42;
    cpu_expect = 1'b1;
    cs0 = cpu_strobes;
    repeat (30) @(negedge clk);
    #1;
    chk(cpu_strobes == cs0, "R6 no strobe without phase change", cpu_strobes - cs0, 0);
    chk(cpu_wait, "R6 still waiting", int'(cpu_wait), 1);
    ph_run = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    chk(cpu_strobes == cs0 + 1, "R6 strobe after phase resumes", cpu_strobes - cs0, 1);
    chk(!cpu_wait, "R6 released", int'(cpu_wait), 0);
    cpu_req = 1'b0;
    repeat (4) @(negedge clk);
    cpu_expect = 1'b0;

    // R3: idle CPU leaves the CPU part silent; run past a full line.
    cs0 = cpu_strobes;
    repeat (1000) @(negedge clk);
    #1;
    chk(cpu_strobes == cs0, "R3 silent without request", cpu_strobes - cs0, 0);
    chk(ls_seen >= 1, "R1 line_start observed", ls_seen, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule